// File: doc/BRIEF.md
# Arithmetic Condition Code Generator

This block turns the outcome of an integer operation into a 2-bit condition code. The caller presents an operation selector together with up to three 64-bit values: a first operand, a second operand and the result that its own datapath already produced. The block does no arithmetic on the caller's behalf. It only classifies the values: sign, zero, overflow, carry and borrow. For add-with-carry and subtract-with-borrow it infers the hidden carry-in or borrow-in from how the result relates to the operands.

Every operation has a narrow form that looks at the low half of each operand and a wide form that looks at the full width. Bit 0 of the selector picks the form and bits 5..1 pick the operation. A request is accepted on any cycle in which `in_valid` is high. The code appears on `cc_out`, with `out_valid` high, on the following cycle. Between requests the last code is held. A selector that names no operation yields code 0 and raises `sel_err` for that one result cycle.

Top module: `cond_code_gen`

## Requirements
- R1: Selectors 4/5 are signed compare (narrow/wide) and 6/7 are unsigned compare. The code is 0 when the first operand equals the second, 1 when it is less and 2 when it is greater.
- R2: Selectors 8/9 are signed add. The code is 3 when both operands share a sign and the result is nonzero with the opposite sign. Otherwise it is 1 for a negative result, 2 for a positive result and 0 for a zero result.
- R3: Selectors 10/11 are signed subtract. The code is 3 when the first operand is positive, the second is negative and the result is negative, or when the first is negative, the second is positive and the result is positive. Otherwise the sign/zero coding of R2 applies.
- R4: Selectors 12/13 are logical add. The code is (result nonzero) + 2 × (result below first operand, unsigned).
- R5: Selectors 14/15 are logical add with carry-in. With t = result − first operand, the carry is (t < second operand) or (result < first operand), and the code is (result nonzero) + 2 × carry.
- R6: Selectors 16/17 are logical subtract without borrow-in. The code is 2 for a zero result. For a nonzero result it is 1 when the second operand exceeds the first and 3 otherwise.
- R7: Selectors 18/19 are logical subtract with borrow-in. A borrow-in is assumed when the result differs from first − second. The borrow-out is second ≥ first with a borrow-in and second > first without one. The code is (result nonzero) + 2 × (no borrow-out).
- R8: The following selectors classify the result alone. Selectors 20/21 (absolute) give 3 for the most negative value, 2 for other nonzero values and 0 for zero. Selectors 22/23 (negative absolute) give 1 for nonzero and 0 for zero. Selectors 24/25 (complement) give 3 for the most negative value, 1 for negative, 2 for positive and 0 for zero.
- R9: Selector 26 checks a 64-bit product held in the result. The code is 0 for zero, 3 when bits 63..31 are neither all zeros nor all ones, and otherwise 1 for negative and 2 for positive. Selector 27 checks a 128-bit product, with the high half in the first operand and the low half in the second. The code is 0 when both halves are zero, 3 when the high half is not a copy of bit 63 of the low half, and otherwise 1 when the high half is negative and 2 when it is not.
- R10: Selectors 0 to 3 output their own value as the code, whatever the operands.
- R11: Narrow selectors (even values 4 to 26, except 26, which reads the full product) use only bits 31..0 of each operand; bits 63..32 have no effect.
- R12: Selectors 28 to 63 give code 0 with `sel_err` high in the result cycle. `sel_err` is low in every cycle that does not follow an accepted request with such a selector.
- R13: After reset `out_valid`, `cc_out` and `sel_err` are 0. A request accepted at one rising edge shows its code and `out_valid` = 1 after that edge. With `in_valid` low, `out_valid` is 0 and `cc_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present this cycle |
| in_sel | input | 6 | Operation selector; bit 0 picks wide form |
| opa | input | 64 | First operand (high product half for selector 27) |
| opb | input | 64 | Second operand (low product half for selector 27) |
| res | input | 64 | Result produced by the caller's datapath |
| out_valid | output | 1 | Code from the previous cycle's request is on `cc_out` |
| cc_out | output | 2 | Condition code |
| sel_err | output | 1 | Previous request carried an unknown selector |

## Verification
The output stage is a single register, so any fault in a classifying lane or in the selector decode shows on `cc_out` exactly one cycle after the offending request. A lost clock enable shows as a code that changes while `in_valid` is low, on the first idle cycle. The vectors sit on the boundaries where the lanes diverge: the most negative value, results of exactly zero, operands that are equal or differ by one, and the two wrap points of the carry and borrow recovery. Junk in the upper operand halves exposes a narrow lane that reads the wrong bits.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  localparam int SEL_W = 6;

  // Operation field, selector bits 5..1
  typedef enum logic [SEL_W-2:0] {
    OP_CONST_LO = 5'd0,
    OP_CONST_HI = 5'd1,
    OP_SCMP     = 5'd2,
    OP_UCMP     = 5'd3,
    OP_SADD     = 5'd4,
    OP_SSUB     = 5'd5,
    OP_LADD     = 5'd6,
    OP_LADDC    = 5'd7,
    OP_LSUB     = 5'd8,
    OP_LSUBB    = 5'd9,
    OP_ABS      = 5'd10,
    OP_NABS     = 5'd11,
    OP_CPL      = 5'd12,
    OP_MUL      = 5'd13
  } op_e;

  typedef struct packed {
    logic [1:0] scmp;
    logic [1:0] ucmp;
    logic [1:0] sadd;
    logic [1:0] ssub;
    logic [1:0] ladd;
    logic [1:0] laddc;
    logic [1:0] lsub;
    logic [1:0] lsubb;
    logic [1:0] absv;
    logic [1:0] nabs;
    logic [1:0] cpl;
  } lane_cc_t;

endpackage

// File: rtl/ccg_lane.sv
module ccg_lane
  import ccg_pkg::*;
#(
  parameter int LW = 32
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic [LW-1:0] r,
  output lane_cc_t      codes
);

  localparam int M = LW - 1;
  localparam logic [LW-1:0] MOST_NEG = {1'b1, {M{1'b0}}};

  logic          a_neg, b_neg, r_neg;
  logic          a_pos, b_pos, r_pos;
  logic          r_nz;
  logic [1:0]    r_sign_cc;
  logic [LW-1:0] diff_ab;
  logic [LW-1:0] carry_sum;
  logic          carry_out;
  logic          borrow_in;
  logic          borrow_out;
  logic          sadd_ov, ssub_ov;

  always_comb begin
    a_neg     = a[M];
    b_neg     = b[M];
    r_neg     = r[M];
    r_nz      = (r != '0);
    a_pos     = !a[M] && (a != '0);
    b_pos     = !b[M] && (b != '0);
    r_pos     = !r[M] && r_nz;
    r_sign_cc = r_neg ? 2'd1 : (r_nz ? 2'd2 : 2'd0);

    sadd_ov = (a_pos && b_pos && r_neg) || (a_neg && b_neg && r_pos);
    ssub_ov = (a_pos && b_neg && r_neg) || (a_neg && b_pos && r_pos);

    // carry-in recovery: r - a equals b plus the carry that came in
    carry_sum = r - a;
    carry_out = (carry_sum < b) || (r < a);

    // borrow-in recovery: any departure from a - b means a borrow came in
    diff_ab    = a - b;
    borrow_in  = (r != diff_ab);
    borrow_out = borrow_in ? (b >= a) : (b > a);

    codes.scmp  = (a == b) ? 2'd0 : (($signed(a) < $signed(b)) ? 2'd1 : 2'd2);
    codes.ucmp  = (a == b) ? 2'd0 : ((a < b) ? 2'd1 : 2'd2);
    codes.sadd  = sadd_ov ? 2'd3 : r_sign_cc;
    codes.ssub  = ssub_ov ? 2'd3 : r_sign_cc;
    codes.ladd  = {(r < a), r_nz};
    codes.laddc = {carry_out, r_nz};
    codes.lsub  = !r_nz ? 2'd2 : ((b > a) ? 2'd1 : 2'd3);
    codes.lsubb = {!borrow_out, r_nz};
    codes.absv  = (r == MOST_NEG) ? 2'd3 : (r_nz ? 2'd2 : 2'd0);
    codes.nabs  = {1'b0, r_nz};
    codes.cpl   = (r == MOST_NEG) ? 2'd3 : r_sign_cc;
  end

  always_comb begin
    if (codes.sadd == 2'd3) begin
      AST_SADD_OV_SIGNS: assert (a[M] == b[M] && r[M] != a[M]); // R2
    end
    if (codes.ladd[1]) begin
      AST_LADD_WRAPPED: assert ((a + b) == r ? (b != '0) : 1'b1); // R4
    end
    if (codes.lsub == 2'd2) begin
      AST_LSUB_ZERO_RES: assert (r == '0); // R6
    end
  end

endmodule

// File: rtl/ccg_mul.sv
module ccg_mul #(
  parameter int W = 64
) (
  input  logic [W-1:0] hi_half,
  input  logic [W-1:0] lo_half,
  input  logic [W-1:0] prod,
  output logic [1:0]   cc_narrow,
  output logic [1:0]   cc_wide
);

  localparam int HALF = W / 2;

  logic [HALF:0] top_bits;
  logic          top_uniform;
  logic          wide_fits;

  always_comb begin
    // narrow product: the upper half plus the narrow sign bit must agree
    top_bits    = prod[W-1:HALF-1];
    top_uniform = (top_bits == '0) || (&top_bits);
    if (prod == '0)        cc_narrow = 2'd0;
    else if (!top_uniform) cc_narrow = 2'd3;
    else if (prod[W-1])    cc_narrow = 2'd1;
    else                   cc_narrow = 2'd2;

    // wide product: the high half must be a sign copy of the low half
    wide_fits = (hi_half == {W{lo_half[W-1]}});
    if (hi_half == '0 && lo_half == '0) cc_wide = 2'd0;
    else if (!wide_fits)                cc_wide = 2'd3;
    else if (hi_half[W-1])              cc_wide = 2'd1;
    else                                cc_wide = 2'd2;
  end

  always_comb begin
    if (cc_wide == 2'd1) begin
      AST_MUL_WIDE_NEG: assert (lo_half[W-1]); // R9
    end
  end

endmodule

// File: rtl/ccg_decode.sv
module ccg_decode
  import ccg_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  lane_cc_t         cc_n,
  input  lane_cc_t         cc_w,
  input  logic [1:0]       mul_n,
  input  logic [1:0]       mul_w,
  output logic [1:0]       cc,
  output logic             unknown
);

  lane_cc_t   pick;
  logic [1:0] mul_pick;

  always_comb begin
    pick     = sel[0] ? cc_w  : cc_n;
    mul_pick = sel[0] ? mul_w : mul_n;
    cc       = 2'd0;
    unknown  = 1'b0;
    case (sel[SEL_W-1:1])
      OP_CONST_LO, OP_CONST_HI: cc = sel[1:0];
      OP_SCMP:  cc = pick.scmp;
      OP_UCMP:  cc = pick.ucmp;
      OP_SADD:  cc = pick.sadd;
      OP_SSUB:  cc = pick.ssub;
      OP_LADD:  cc = pick.ladd;
      OP_LADDC: cc = pick.laddc;
      OP_LSUB:  cc = pick.lsub;
      OP_LSUBB: cc = pick.lsubb;
      OP_ABS:   cc = pick.absv;
      OP_NABS:  cc = pick.nabs;
      OP_CPL:   cc = pick.cpl;
      OP_MUL:   cc = mul_pick;
      default:  unknown = 1'b1;
    endcase
  end

endmodule

// File: rtl/cond_code_gen.sv
module cond_code_gen
  import ccg_pkg::*;
#(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SEL_W-1:0] in_sel,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [W-1:0]     res,
  output logic             out_valid,
  output logic [1:0]       cc_out,
  output logic             sel_err
);

  localparam int HALF   = W / 2;
  localparam int NLANES = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  lane_cc_t   lane_cc [NLANES];
  logic [1:0] mul_n, mul_w;
  logic [1:0] cc_comb;
  logic       unk_comb;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? HALF : W;
    ccg_lane #(.LW(LW)) u_lane (
      .a     (opa[LW-1:0]),
      .b     (opb[LW-1:0]),
      .r     (res[LW-1:0]),
      .codes (lane_cc[g])
    );
  end

  ccg_mul #(.W(W)) u_mul (
    .hi_half   (opa),
    .lo_half   (opb),
    .prod      (res),
    .cc_narrow (mul_n),
    .cc_wide   (mul_w)
  );

  ccg_decode u_decode (
    .sel     (in_sel),
    .cc_n    (lane_cc[0]),
    .cc_w    (lane_cc[1]),
    .mul_n   (mul_n),
    .mul_w   (mul_w),
    .cc      (cc_comb),
    .unknown (unk_comb)
  );

  logic       vld_d, err_d;
  logic [1:0] cc_d;
  logic       vld_q, err_q;
  logic [1:0] cc_q;

  always_comb begin
    vld_d = in_valid;
    err_d = in_valid && unk_comb;
    cc_d  = in_valid ? cc_comb : cc_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      cc_q  <= 2'd0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
      cc_q  <= cc_d;
    end
  end

  assign out_valid = vld_q;
  assign sel_err   = err_q;
  assign cc_out    = cc_q;

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_q) in_valid |=> out_valid); // R13
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q) !in_valid |=> ($stable(cc_out) && !out_valid)); // R13
  AST_ERR_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_q) sel_err |-> (out_valid && cc_out == 2'd0)); // R12
  AST_ERR_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_q) !in_valid |=> !sel_err); // R12
  AST_CONST_PASS: assert property (@(posedge clk) disable iff (!rst_q) (in_valid && in_sel[SEL_W-1:2] == '0) |=> (cc_out == $past(in_sel[1:0]))); // R10
  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_q) (in_valid && in_sel[SEL_W-1:2] == 'd1 && opa == opb) |=> (cc_out == 2'd0)); // R1

endmodule

// File: tb/test_cond_code_gen.sv
module test_cond_code_gen;

  typedef struct packed {
    logic [31:0] req;
    logic [5:0]  sel;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
    logic [1:0]  cc;
    logic        err;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MNEG = 64'h8000_0000_0000_0000;
  localparam logic [63:0] JUNK = 64'hDEAD_BEEF_0BAD_F00D;
  localparam int NV = 55;

  localparam vec_t TBL [NV] = '{
    '{32'd1, 6'd4, 64'd5, 64'd5, 64'd0, 2'd0, 1'b0},                 // R1
    '{32'd1, 6'd4, 64'hFFFF_FFFF, 64'd1, 64'd0, 2'd1, 1'b0},
    '{32'd1, 6'd6, 64'hFFFF_FFFF, 64'd1, 64'd0, 2'd2, 1'b0},
    '{32'd1, 6'd5, MNEG, 64'd0, 64'd0, 2'd1, 1'b0},
    '{32'd1, 6'd7, 64'd1, 64'd2, 64'd0, 2'd1, 1'b0},
    '{32'd2, 6'd8, 64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 2'd3, 1'b0}, // R2
    '{32'd2, 6'd8, 64'd5, 64'hFFFF_FFFD, 64'd2, 2'd2, 1'b0},
    '{32'd2, 6'd8, 64'd3, 64'hFFFF_FFFD, 64'd0, 2'd0, 1'b0},
    '{32'd2, 6'd9, MNEG, MNEG, 64'd0, 2'd0, 1'b0},
    '{32'd2, 6'd9, ONES, ONES, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1, 1'b0},
    '{32'd3, 6'd10, 64'h7FFF_FFFF, 64'hFFFF_FFFF, 64'h8000_0000, 2'd3, 1'b0}, // R3
    '{32'd3, 6'd11, 64'd2, 64'd5, 64'hFFFF_FFFF_FFFF_FFFD, 2'd1, 1'b0},
    '{32'd3, 6'd10, 64'h8000_0000, 64'd1, 64'h7FFF_FFFF, 2'd3, 1'b0},
    '{32'd4, 6'd12, 64'hFFFF_FFFF, 64'd1, 64'd0, 2'd2, 1'b0},         // R4
    '{32'd4, 6'd12, 64'd1, 64'd2, 64'd3, 2'd1, 1'b0},
    '{32'd4, 6'd12, 64'hFFFF_FFFF, 64'd2, 64'd1, 2'd3, 1'b0},
    '{32'd4, 6'd13, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0},
    '{32'd5, 6'd14, 64'hFFFF_FFFF, 64'd0, 64'd0, 2'd2, 1'b0},         // R5
    '{32'd5, 6'd14, 64'd0, 64'hFFFF_FFFF, 64'd0, 2'd2, 1'b0},
    '{32'd5, 6'd15, 64'd1, 64'd1, 64'd3, 2'd1, 1'b0},
    '{32'd6, 6'd16, 64'd5, 64'd5, 64'd0, 2'd2, 1'b0},                 // R6
    '{32'd6, 6'd16, 64'd3, 64'd5, 64'hFFFF_FFFE, 2'd1, 1'b0},
    '{32'd6, 6'd16, 64'd5, 64'd3, 64'd2, 2'd3, 1'b0},
    '{32'd6, 6'd17, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1, 1'b0},
    '{32'd7, 6'd18, 64'd5, 64'd5, 64'd0, 2'd2, 1'b0},                 // R7
    '{32'd7, 6'd18, 64'd5, 64'd5, 64'hFFFF_FFFF, 2'd1, 1'b0},
    '{32'd7, 6'd19, 64'd6, 64'd5, 64'd0, 2'd2, 1'b0},
    '{32'd7, 6'd19, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 2'd1, 1'b0},
    '{32'd8, 6'd20, 64'd0, 64'd0, 64'h8000_0000, 2'd3, 1'b0},         // R8
    '{32'd8, 6'd20, 64'd0, 64'd0, 64'd5, 2'd2, 1'b0},
    '{32'd8, 6'd20, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0},
    '{32'd8, 6'd22, 64'd0, 64'd0, 64'hFFFF_FFFB, 2'd1, 1'b0},
    '{32'd8, 6'd23, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0},
    '{32'd8, 6'd24, 64'd0, 64'd0, 64'h8000_0000, 2'd3, 1'b0},
    '{32'd8, 6'd25, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFB, 2'd1, 1'b0},
    '{32'd8, 6'd25, 64'd0, 64'd0, 64'd5, 2'd2, 1'b0},
    '{32'd9, 6'd26, 64'd0, 64'd0, 64'h0000_0000_8000_0000, 2'd3, 1'b0}, // R9
    '{32'd9, 6'd26, 64'd0, 64'd0, 64'hFFFF_FFFF_8000_0000, 2'd1, 1'b0},
    '{32'd9, 6'd26, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0},
    '{32'd9, 6'd26, 64'd0, 64'd0, 64'h7FFF_FFFF, 2'd2, 1'b0},
    '{32'd9, 6'd27, 64'd0, MNEG, 64'd0, 2'd3, 1'b0},
    '{32'd9, 6'd27, ONES, MNEG, 64'd0, 2'd1, 1'b0},
    '{32'd9, 6'd27, 64'd0, 64'd5, 64'd0, 2'd2, 1'b0},
    '{32'd9, 6'd27, 64'd0, 64'd0, 64'd0, 2'd0, 1'b0},
    '{32'd10, 6'd0, JUNK, JUNK, JUNK, 2'd0, 1'b0},                    // R10
    '{32'd10, 6'd1, JUNK, JUNK, JUNK, 2'd1, 1'b0},
    '{32'd10, 6'd2, JUNK, JUNK, JUNK, 2'd2, 1'b0},
    '{32'd10, 6'd3, JUNK, JUNK, JUNK, 2'd3, 1'b0},
    '{32'd11, 6'd4, 64'hFFFF_FFFF_0000_0005, 64'd5, 64'd0, 2'd0, 1'b0}, // R11
    '{32'd11, 6'd12, 64'h1234_5678_FFFF_FFFF, 64'd0, 64'hABCD_0000_0000_0000, 2'd2, 1'b0},
    '{32'd11, 6'd20, 64'd0, 64'd0, 64'hFFFF_FFFF_0000_0000, 2'd0, 1'b0},
    '{32'd11, 6'd24, 64'd0, 64'd0, 64'h0000_0001_8000_0000, 2'd3, 1'b0},
    '{32'd12, 6'd28, JUNK, JUNK, JUNK, 2'd0, 1'b1},                   // R12
    '{32'd12, 6'd63, JUNK, JUNK, JUNK, 2'd0, 1'b1},
    '{32'd12, 6'd3, 64'd0, 64'd0, 64'd0, 2'd3, 1'b0}
  };

  logic        clk, rst_n, in_valid;
  logic [5:0]  in_sel;
  logic [63:0] opa, opb, res;
  logic        out_valid, sel_err;
  logic [1:0]  cc_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cond_code_gen i_cond_code_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
    .opa(opa), .opb(opb), .res(res),
    .out_valid(out_valid), .cc_out(cc_out), .sel_err(sel_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [5:0] s,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] r);
    in_valid = v;
    in_sel   = s;
    opa      = a;
    opb      = b;
    res      = r;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 6'd0, 64'd0, 64'd0, 64'd0);
    repeat (3) @(negedge clk);
    chk("R13 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R13 reset cc_out", {62'd0, cc_out}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 after reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R13 after reset sel_err", {63'd0, sel_err}, 64'd0);
    chk("R13 after reset cc_out", {62'd0, cc_out}, 64'd0);

    // table walk, back to back requests
    for (int k = 0; k < NV; k++) begin
      drive(1'b1, TBL[k].sel, TBL[k].a, TBL[k].b, TBL[k].r);
      @(negedge clk);
      chk($sformatf("R%0d vec %0d valid", TBL[k].req, k), {63'd0, out_valid}, 64'd1);
      chk($sformatf("R%0d vec %0d sel %0d cc", TBL[k].req, k, TBL[k].sel),
          {62'd0, cc_out}, {62'd0, TBL[k].cc});
      chk($sformatf("R%0d vec %0d err", TBL[k].req, k), {63'd0, sel_err}, {63'd0, TBL[k].err});
    end

    // R13: idle cycles hold the last code (3) while inputs change
    drive(1'b0, 6'd0, JUNK, JUNK, JUNK);
    @(negedge clk);
    chk("R13 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R13 idle hold cc", {62'd0, cc_out}, 64'd3);
    drive(1'b0, 6'd9, 64'd1, 64'd1, 64'd0);
    @(negedge clk);
    chk("R13 idle hold cc second", {62'd0, cc_out}, 64'd3);

    // R12: a lone unknown selector raises the flag for one cycle only
    drive(1'b1, 6'd40, 64'd0, 64'd0, 64'd0);
    @(negedge clk);
    chk("R12 unknown err", {63'd0, sel_err}, 64'd1);
    chk("R12 unknown cc zero", {62'd0, cc_out}, 64'd0);
    drive(1'b0, 6'd40, 64'd0, 64'd0, 64'd0);
    @(negedge clk);
    chk("R12 err dropped", {63'd0, sel_err}, 64'd0);

    // R11: upper-half junk on a narrow signed compare (low -1 vs low 1)
    drive(1'b1, 6'd4, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 64'd0);
    @(negedge clk);
    chk("R11 narrow compare ignores upper", {62'd0, cc_out}, 64'd1);
    // R1: same operands through the wide signed compare
    drive(1'b1, 6'd5, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 64'd0);
    @(negedge clk);
    chk("R1 wide compare greater", {62'd0, cc_out}, 64'd2);
    drive(1'b0, 6'd0, 64'd0, 64'd0, 64'd0);
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R13 actual expired expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule